// File: doc/BRIEF.md
# Return-Address Stack with Occupancy Watermarks

This block is a hardware last-in-first-out store for program addresses. A sequencer uses it to nest subroutine calls, interrupt entries and loops. Each push saves an address and each pop discards the newest one. The current top entry and the number of occupied entries can always be read. Pushing and popping in the same cycle overwrites the top entry in place.

The block also raises a level-style interrupt request whenever occupancy leaves a safe middle band. The band is too close to empty at the bottom and too close to full at the top. Software can then move entries out to memory or back in before the store runs out of room or data. Pushing into a full stack and popping an empty one are hard faults. Each fault is refused and latched in a sticky flag until a clear input drops it.

Internally, a zone state machine follows occupancy through five named states. EMPTY means no entries. LOW means one up to, but not including, the lower mark. SAFE means the lower mark up to and including the upper mark. HIGH means above the upper mark but not full. FULL means every entry is in use. The state register moves only on an accepted push (transition GROW) or an accepted pop (transition SHRINK). Each move goes to the zone that matches the new count, so GROW steps EMPTY to LOW, LOW to SAFE, SAFE to HIGH and HIGH to FULL, and SHRINK walks the same path backwards. A replace, an idle cycle or a refused operation is transition HOLD, which keeps the current zone. The request output is driven from the zone and the enable.

Top module: `rstk`

## Requirements
- R1: After reset the fill count is 0, the top-of-stack output is 0, both fault flags are 0, and the level request is 0 while its enable is low.
- R2: A push without pop, when fewer than 33 entries are held, stores the address, raises the fill count by one, and shows that address on the top-of-stack output from the next cycle.
- R3: A pop without push, when at least one entry is held, lowers the fill count by one and shows the previously pushed entry on the top-of-stack output from the next cycle.
- R4: A push and a pop in the same cycle with at least one entry held replace the top entry with the new address and leave the fill count unchanged. With the stack empty, the pair acts as a plain push and no fault is flagged.
- R5: A push without pop when 33 entries are held is refused: fill and top stay unchanged and the sticky overflow flag is set.
- R6: A pop without push on an empty stack is refused: fill stays 0, the top-of-stack output reads 0, and the sticky underflow flag is set.
- R7: The clear input drops both fault flags on the next cycle. A fault occurring in the same cycle as a clear wins, and its flag stays set.
- R8: With the enable high, the level request is 1 while the fill count is below 3.
- R9: With the enable high, the level request is 1 while the fill count is above 28.
- R10: The level request is 0 while the fill count is within 3 to 28 inclusive, and it is 0 whenever the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_addr_i | input | 24 | Address to store on push or replace |
| lvl_irq_en_i | input | 1 | Enable for the occupancy request |
| err_clr_i | input | 1 | Clears both fault flags |
| tos_o | output | 24 | Newest entry, 0 when empty |
| fill_o | output | 6 | Number of occupied entries |
| lvl_irq_o | output | 1 | Occupancy-out-of-band request |
| overflow_o | output | 1 | Sticky push-when-full flag |
| underflow_o | output | 1 | Sticky pop-when-empty flag |

## Verification
A table-driven sequence mixes pushes, pops, replaces, idle cycles and enable changes at shallow depth. Its fill and top values separate true last-in-first-out order from overwriting or stale reads, and it covers a replace on an empty stack. A directed climb to 33 entries and a full drain check the request at every depth. These sweeps show that the 2/3 and 28/29 edges are placed exactly, and each entry's readback detects indexing slips. Refused operations at both ends, together with clears that coincide with new faults, separate sticky behaviour, refusal and set-over-clear priority.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [2:0] {
        ZN_EMPTY,
        ZN_LOW,
        ZN_SAFE,
        ZN_HIGH,
        ZN_FULL
    } zone_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP
    } op_e;

    function automatic zone_e classify(int f, int depth, int lo, int hi);
        if (f == 0)
            return ZN_EMPTY;
        else if (f >= depth)
            return ZN_FULL;
        else if (f < lo)
            return ZN_LOW;
        else if (f > hi)
            return ZN_HIGH;
        else
            return ZN_SAFE;
    endfunction

endpackage

// File: rtl/rstk_decode.sv
module rstk_decode
    import rstk_pkg::*;
(
    input  logic push,
    input  logic pop,
    input  logic is_empty,
    input  logic is_full,
    output op_e  op,
    output logic ovf_evt,
    output logic unf_evt
);

    always_comb begin
        op      = OP_IDLE;
        ovf_evt = 1'b0;
        unf_evt = 1'b0;
        unique case ({push, pop})
            2'b10: begin
                if (is_full) ovf_evt = 1'b1;
                else         op      = OP_PUSH;
            end
            2'b01: begin
                if (is_empty) unf_evt = 1'b1;
                else          op      = OP_POP;
            end
            2'b11: op = is_empty ? OP_PUSH : OP_SWAP;
            default: op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/rstk_zone_fsm.sv
module rstk_zone_fsm
    import rstk_pkg::*;
#(
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  op_e           op,
    output logic [CW-1:0] fill,
    output logic          is_empty,
    output logic          is_full,
    output logic          out_of_band
);

    zone_e         zone, nxt_zone;
    logic [CW-1:0] nxt_fill;

    always_comb begin
        nxt_fill = fill;
        nxt_zone = zone;
        unique case (op)
            OP_PUSH: begin
                nxt_fill = fill + CW'(1);
                nxt_zone = classify(int'(nxt_fill), DEPTH, LOW_MARK, HIGH_MARK);
            end
            OP_POP: begin
                nxt_fill = fill - CW'(1);
                nxt_zone = classify(int'(nxt_fill), DEPTH, LOW_MARK, HIGH_MARK);
            end
            OP_SWAP, OP_IDLE: begin
                nxt_fill = fill;
                nxt_zone = zone;
            end
            default: nxt_zone = zone;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zone <= ZN_EMPTY;
            fill <= '0;
        end else begin
            zone <= nxt_zone;
            fill <= nxt_fill;
        end
    end

    always_comb begin
        is_empty    = 1'b0;
        is_full     = 1'b0;
        out_of_band = 1'b0;
        unique case (zone)
            ZN_EMPTY: begin
                is_empty    = 1'b1;
                out_of_band = 1'b1;
            end
            ZN_LOW:  out_of_band = 1'b1;
            ZN_SAFE: out_of_band = 1'b0;
            ZN_HIGH: out_of_band = 1'b1;
            ZN_FULL: begin
                is_full     = 1'b1;
                out_of_band = 1'b1;
            end
            default: out_of_band = 1'b0;
        endcase
    end

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int AW    = 24,
    parameter int DEPTH = 33,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [CW-1:0] widx,
    input  logic [AW-1:0] wdata,
    input  logic [CW-1:0] ridx,
    output logic [AW-1:0] rdata
);

    logic [AW-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && widx == CW'(g))
                slot[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ridx == CW'(i))
                rdata = slot[i];
        end
    end

endmodule

// File: rtl/rstk.sv
module rstk
    import rstk_pkg::*;
#(
    parameter int AW        = 24,
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic                         pop_i,
    input  logic [AW-1:0]                push_addr_i,
    input  logic                         lvl_irq_en_i,
    input  logic                         err_clr_i,
    output logic [AW-1:0]                tos_o,
    output logic [$clog2(DEPTH+1)-1:0]   fill_o,
    output logic                         lvl_irq_o,
    output logic                         overflow_o,
    output logic                         underflow_o
);

    localparam int CW = $clog2(DEPTH + 1);

    op_e           op;
    logic          ovf_evt, unf_evt;
    logic          is_empty, is_full, out_of_band;
    logic [CW-1:0] fill;
    logic [CW-1:0] widx;
    logic [AW-1:0] rdata;
    logic          we;

    rstk_decode u_dec (
        .push     (push_i),
        .pop      (pop_i),
        .is_empty (is_empty),
        .is_full  (is_full),
        .op       (op),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt)
    );

    rstk_zone_fsm #(
        .DEPTH     (DEPTH),
        .LOW_MARK  (LOW_MARK),
        .HIGH_MARK (HIGH_MARK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .fill        (fill),
        .is_empty    (is_empty),
        .is_full     (is_full),
        .out_of_band (out_of_band)
    );

    assign we   = (op == OP_PUSH) || (op == OP_SWAP);
    assign widx = (op == OP_PUSH) ? fill : fill - CW'(1);

    rstk_store #(
        .AW    (AW),
        .DEPTH (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (we),
        .widx  (widx),
        .wdata (push_addr_i),
        .ridx  (fill - CW'(1)),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow_o  <= 1'b0;
            underflow_o <= 1'b0;
        end else begin
            overflow_o  <= ovf_evt | (overflow_o  & ~err_clr_i);
            underflow_o <= unf_evt | (underflow_o & ~err_clr_i);
        end
    end

    assign tos_o     = is_empty ? '0 : rdata;
    assign fill_o    = fill;
    assign lvl_irq_o = out_of_band & lvl_irq_en_i;

endmodule

// File: rtl/rstk_checks.sv
module rstk_checks #(
    parameter int AW        = 24,
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_i,
    input logic          pop_i,
    input logic [AW-1:0] push_addr_i,
    input logic          lvl_irq_en_i,
    input logic          err_clr_i,
    input logic [AW-1:0] tos_o,
    input logic [CW-1:0] fill_o,
    input logic          lvl_irq_o,
    input logic          overflow_o,
    input logic          underflow_o
);

    assert_push_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && fill_o < CW'(DEPTH)) |=>
            (fill_o == $past(fill_o) + CW'(1) && tos_o == $past(push_addr_i)));

    assert_pop_shrink_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && fill_o != '0) |=> (fill_o == $past(fill_o) - CW'(1)));

    assert_swap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && fill_o != '0) |=>
            (fill_o == $past(fill_o) && tos_o == $past(push_addr_i)));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && fill_o == CW'(DEPTH)) |=> (overflow_o && $stable(fill_o) && $stable(tos_o)));

    assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_o <= CW'(DEPTH));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && fill_o == '0) |=> (underflow_o && fill_o == '0 && tos_o == '0));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !(push_i ^ pop_i)) |=> (!overflow_o && !underflow_o));

    assert_low_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_irq_en_i && fill_o < CW'(LOW_MARK)) |-> lvl_irq_o);

    assert_high_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_irq_en_i && fill_o > CW'(HIGH_MARK)) |-> lvl_irq_o);

    assert_quiet_band_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_o >= CW'(LOW_MARK) && fill_o <= CW'(HIGH_MARK)) |-> !lvl_irq_o);

    assert_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_irq_en_i |-> !lvl_irq_o);

endmodule

bind rstk rstk_checks #(
    .AW        (AW),
    .DEPTH     (DEPTH),
    .LOW_MARK  (LOW_MARK),
    .HIGH_MARK (HIGH_MARK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .push_addr_i  (push_addr_i),
    .lvl_irq_en_i (lvl_irq_en_i),
    .err_clr_i    (err_clr_i),
    .tos_o        (tos_o),
    .fill_o       (fill_o),
    .lvl_irq_o    (lvl_irq_o),
    .overflow_o   (overflow_o),
    .underflow_o  (underflow_o)
);

// File: tb/rstk_test.sv
`timescale 1ns/1ps
module rstk_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0, lvl_irq_en_i = 1'b0, err_clr_i = 1'b0;
    logic [23:0] push_addr_i = '0;
    logic [23:0] tos_o;
    logic [5:0]  fill_o;
    logic        lvl_irq_o, overflow_o, underflow_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rstk uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_i),
        .pop_i        (pop_i),
        .push_addr_i  (push_addr_i),
        .lvl_irq_en_i (lvl_irq_en_i),
        .err_clr_i    (err_clr_i),
        .tos_o        (tos_o),
        .fill_o       (fill_o),
        .lvl_irq_o    (lvl_irq_o),
        .overflow_o   (overflow_o),
        .underflow_o  (underflow_o)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic        en;
        logic [23:0] addr;
        logic [5:0]  fill;
        logic [23:0] tos;
        logic        irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 24'h100001, 6'd1, 24'h100001, 1'b0},
        '{1'b1, 1'b0, 1'b1, 24'h200002, 6'd2, 24'h200002, 1'b1},
        '{1'b1, 1'b0, 1'b1, 24'h300003, 6'd3, 24'h300003, 1'b0},
        '{1'b1, 1'b1, 1'b1, 24'hABCDEF, 6'd3, 24'hABCDEF, 1'b0},
        '{1'b0, 1'b1, 1'b1, 24'h000000, 6'd2, 24'h200002, 1'b1},
        '{1'b0, 1'b1, 1'b0, 24'h000000, 6'd1, 24'h100001, 1'b0},
        '{1'b1, 1'b0, 1'b0, 24'h0F0F0F, 6'd2, 24'h0F0F0F, 1'b0},
        '{1'b0, 1'b0, 1'b1, 24'h000000, 6'd2, 24'h0F0F0F, 1'b1},
        '{1'b0, 1'b1, 1'b1, 24'h000000, 6'd1, 24'h100001, 1'b1},
        '{1'b0, 1'b1, 1'b1, 24'h000000, 6'd0, 24'h000000, 1'b1},
        '{1'b1, 1'b1, 1'b1, 24'h123456, 6'd1, 24'h123456, 1'b1},
        '{1'b0, 1'b1, 1'b0, 24'h000000, 6'd0, 24'h000000, 1'b0}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(logic pu, logic po, logic [23:0] a, logic en, logic clr);
        @(negedge clk);
        push_i = pu; pop_i = po; push_addr_i = a; lvl_irq_en_i = en; err_clr_i = clr;
        @(posedge clk);
        #1;
        push_i = 1'b0; pop_i = 1'b0; err_clr_i = 1'b0;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 fill", 32'(fill_o), 0);
        check("R1 tos", 32'(tos_o), 0);
        check("R1 overflow", 32'(overflow_o), 0);
        check("R1 underflow", 32'(underflow_o), 0);
        check("R1 irq", 32'(lvl_irq_o), 0);

        // table walk: R2 R3 R4 R8 R10
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].push, VEC[i].pop, VEC[i].addr, VEC[i].en, 1'b0);
            check($sformatf("R2 R3 R4 vec%0d fill", i), 32'(fill_o), 32'(VEC[i].fill));
            check($sformatf("R2 R3 R4 vec%0d tos", i), 32'(tos_o), 32'(VEC[i].tos));
            check($sformatf("R8 R10 vec%0d irq", i), 32'(lvl_irq_o), 32'(VEC[i].irq));
        end

        // R6 underflow on empty
        step(1'b0, 1'b1, 24'h0, 1'b0, 1'b0);
        check("R6 fill", 32'(fill_o), 0);
        check("R6 tos", 32'(tos_o), 0);
        check("R6 underflow", 32'(underflow_o), 1);
        check("R6 overflow quiet", 32'(overflow_o), 0);
        // R7 clear coinciding with new underflow: set wins
        step(1'b0, 1'b1, 24'h0, 1'b0, 1'b1);
        check("R7 set wins", 32'(underflow_o), 1);
        step(1'b0, 1'b0, 24'h0, 1'b0, 1'b1);
        check("R7 clear", 32'(underflow_o), 0);

        // climb to full, R2 R8 R9 R10 at every depth
        for (int k = 1; k <= 33; k++) begin
            step(1'b1, 1'b0, 24'h010000 + 24'(k), 1'b1, 1'b0);
            check($sformatf("R2 climb fill %0d", k), 32'(fill_o), 32'(k));
            check($sformatf("R2 climb tos %0d", k), 32'(tos_o), 32'h010000 + 32'(k));
            check($sformatf("R8 R9 R10 climb irq %0d", k), 32'(lvl_irq_o),
                  (k < 3 || k > 28) ? 32'd1 : 32'd0);
        end

        // R5 push at full
        step(1'b1, 1'b0, 24'hFFFFFF, 1'b1, 1'b0);
        check("R5 fill held", 32'(fill_o), 33);
        check("R5 tos held", 32'(tos_o), 32'h010021);
        check("R5 overflow", 32'(overflow_o), 1);
        // R4 replace at full
        step(1'b1, 1'b1, 24'hEEEEEE, 1'b1, 1'b0);
        check("R4 full swap fill", 32'(fill_o), 33);
        check("R4 full swap tos", 32'(tos_o), 32'hEEEEEE);
        // R7 clear with new overflow, then plain clear
        step(1'b1, 1'b0, 24'h111111, 1'b1, 1'b1);
        check("R7 ovf set wins", 32'(overflow_o), 1);
        check("R5 tos after refuse", 32'(tos_o), 32'hEEEEEE);
        step(1'b0, 1'b0, 24'h0, 1'b0, 1'b1);
        check("R7 ovf cleared", 32'(overflow_o), 0);
        check("R10 enable off at full", 32'(lvl_irq_o), 0);

        // drain, R3 R8 R9 R10
        for (int k = 32; k >= 0; k--) begin
            step(1'b0, 1'b1, 24'h0, 1'b1, 1'b0);
            check($sformatf("R3 drain fill %0d", k), 32'(fill_o), 32'(k));
            check($sformatf("R3 drain tos %0d", k), 32'(tos_o),
                  (k == 0) ? 32'd0 : 32'h010000 + 32'(k));
            check($sformatf("R8 R9 R10 drain irq %0d", k), 32'(lvl_irq_o),
                  (k < 3 || k > 28) ? 32'd1 : 32'd0);
        end
        check("R6 no flag after drain", 32'(underflow_o), 0);

        finish_up();
    end

endmodule